// File: doc/BRIEF.md
# Wave Launch Scalar Register Initializer

When a wavefront is launched, this sequencer fills the wave's first scalar registers before the wave executes its first instruction. A field-enable mask picks the values the kernel expects. The block visits the enabled fields from the lowest bit upward. It places each field's 32-bit words into the next free logical scalar slots, and it emits them through a write port whose index is a caller-given base plus a running offset.

Some fields are copied straight from the launch values: a four-word segment descriptor, three 64-bit pointers, the flat scratch pair, and the workgroup IDs. Others are computed. These are the three grid workgroup counts, the per-wave private scratch offset and a packed workgroup info word. The ceiling divisions run on one shared bit-serial divider, and the walk pauses while the divider works. A one-cycle done pulse ends every accepted launch.

Top module: `wave_reg_init`

## Requirements
- R1: Fields are emitted in ascending enable-bit order. Each enabled field occupies the next consecutive logical slots, starting at the base index, and a disabled field occupies none. Field bits are: 0 descriptor, 1 dispatch pointer, 2 queue pointer, 3 argument pointer, 4 flat scratch, 5..7 grid counts X/Y/Z, 8..10 workgroup ID X/Y/Z (one word each, copied), 11 wave scratch offset, 12 info word. One launch writes at most 20 words.
- R2: Field 0 writes the four 32-bit descriptor words in four slots, descriptor bits [31:0] first and bits [127:96] last.
- R3: Each pointer field writes the pointer's bits [31:0] into its first slot and bits [63:32] into its second slot.
- R4: Field 4 writes the low 32 bits of the scratch backing location, then the per-work-item scratch byte size.
- R5: Grid count fields write ceil(grid size / workgroup size) for their dimension. No write is made while the quotient is being formed.
- R6: Field 11 writes 1024 × (linear workgroup ID × floor(workgroup work-items / 64) + wave index in workgroup) × scratch KB per wave, modulo 2^32.
- R7: Field 12 writes a word with these fields: bit 31 set only when the wave index is 0; the append term in bits [11:6]; the low 6 bits of ceil(workgroup work-items / wave size) in bits [5:0]; all other bits zero.
- R8: At most one word is written per clock. After the last word, done is high for exactly one cycle. A start seen while a launch is running is ignored.
- R9: A start with an all-zero mask gives done in the following cycle and makes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch request pulse |
| field_en_i | input | 13 | Field enable mask |
| base_idx_i | input | RW | Physical index of the first logical slot |
| seg_desc_i | input | 128 | Private segment descriptor, word 0 in [31:0] |
| disp_ptr_i | input | 64 | Dispatch packet pointer |
| queue_ptr_i | input | 64 | Queue pointer |
| arg_ptr_i | input | 64 | Kernel argument pointer |
| scratch_lo_i | input | 32 | Low word of scratch backing location |
| scratch_item_i | input | 32 | Scratch bytes per work-item |
| grid_size_i | input | 96 | Grid size, X in [31:0], Y in [63:32], Z in [95:64] |
| wg_size_i | input | 96 | Workgroup size per dimension, same packing |
| wg_id_i | input | 96 | Workgroup ID per dimension, same packing |
| wg_lin_i | input | 32 | Linear workgroup ID |
| wg_items_i | input | 32 | Work-items in the workgroup |
| wave_id_i | input | 32 | Wave index within the workgroup |
| wave_size_i | input | 32 | Work-items per wave |
| wave_kb_i | input | 32 | Scratch KB per wave |
| append_i | input | AW | Ordered-append term |
| wr_en_o | output | 1 | Register write strobe |
| wr_idx_o | output | RW | Register write index |
| wr_data_o | output | 32 | Register write data |
| busy_o | output | 1 | Launch in progress |
| done_o | output | 1 | One-cycle end-of-launch pulse |

## Verification
Only the mask is captured at start. The checks therefore assume that every other launch value, and the base index, stays steady from start until done. The bench changes launch values only while the block is idle, and keeps divisors non-zero. The slot-count check assumes the index does not wrap within one launch, so random bases stay below 230. The random masks, operand sizes and wave counts are mixed with directed cases: exact and inexact divisions, wave zero, the empty mask and a start issued mid-launch.

// File: rtl/wave_reg_init.sv
module wave_reg_init #(
  parameter int RW = 8,
  parameter int AW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [12:0]     field_en_i,
  input  logic [RW-1:0]   base_idx_i,
  input  logic [127:0]    seg_desc_i,
  input  logic [63:0]     disp_ptr_i,
  input  logic [63:0]     queue_ptr_i,
  input  logic [63:0]     arg_ptr_i,
  input  logic [31:0]     scratch_lo_i,
  input  logic [31:0]     scratch_item_i,
  input  logic [95:0]     grid_size_i,
  input  logic [95:0]     wg_size_i,
  input  logic [95:0]     wg_id_i,
  input  logic [31:0]     wg_lin_i,
  input  logic [31:0]     wg_items_i,
  input  logic [31:0]     wave_id_i,
  input  logic [31:0]     wave_size_i,
  input  logic [31:0]     wave_kb_i,
  input  logic [AW-1:0]   append_i,
  output logic            wr_en_o,
  output logic [RW-1:0]   wr_idx_o,
  output logic [31:0]     wr_data_o,
  output logic            busy_o,
  output logic            done_o
);
  localparam int DW   = 32;
  localparam int NF   = 13;
  localparam int FW   = $clog2(NF);
  localparam int CNTW = $clog2(DW + 1);
  localparam int NWB  = 6;
  localparam int PADW = DW - 1 - NWB - AW;
  localparam int MAXW = 20;
  localparam logic [NF-1:0] DIV_FIELDS = 13'b1_0000_1110_0000;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DIV} st_t;

  st_t            st;
  logic [NF-1:0]  pend;
  logic [1:0]     wi;
  logic [RW-1:0]  off;
  logic           have_q;
  logic [DW-1:0]  q_r;
  logic [DW:0]    rem;
  logic [DW-1:0]  quo;
  logic [CNTW-1:0] dcnt;
  logic           done_r;

  logic [FW-1:0]  cur;
  logic [1:0]     wlast;
  logic [DW-1:0]  dvd, dvs, wdat, wofs, info;
  logic [DW:0]    rem_sh, rem_n;
  logic [DW-1:0]  quo_n;
  logic           ge, need_div, last_w;
  logic [NF-1:0]  pend_rest;

  always_comb begin
    cur = '0;
    for (int i = NF - 1; i >= 0; i--)
      if (pend[i]) cur = FW'(i);
  end

  assign pend_rest = pend & (pend - 1'b1);
  assign wlast     = (cur == 0) ? 2'd3 : (cur <= 4) ? 2'd1 : 2'd0;
  assign last_w    = (wi == wlast);
  assign need_div  = (st == S_RUN) && DIV_FIELDS[cur] && !have_q;

  always_comb begin
    case (cur)
      4'd5:    begin dvd = grid_size_i[0 +: DW];    dvs = wg_size_i[0 +: DW];    end
      4'd6:    begin dvd = grid_size_i[DW +: DW];   dvs = wg_size_i[DW +: DW];   end
      4'd7:    begin dvd = grid_size_i[2*DW +: DW]; dvs = wg_size_i[2*DW +: DW]; end
      default: begin dvd = wg_items_i;              dvs = wave_size_i;           end
    endcase
  end

  assign rem_sh = {rem[DW-1:0], quo[DW-1]};
  assign ge     = rem_sh >= {1'b0, dvs};
  assign rem_n  = ge ? rem_sh - {1'b0, dvs} : rem_sh;
  assign quo_n  = {quo[DW-2:0], ge};

  assign wofs = ((wg_lin_i * (wg_items_i >> 6)) + wave_id_i) * wave_kb_i << 10;
  assign info = {(wave_id_i == '0), {PADW{1'b0}}, append_i, q_r[NWB-1:0]};

  always_comb begin
    case (cur)
      4'd0:    wdat = seg_desc_i[wi*DW +: DW];
      4'd1:    wdat = wi[0] ? disp_ptr_i[63:32]  : disp_ptr_i[31:0];
      4'd2:    wdat = wi[0] ? queue_ptr_i[63:32] : queue_ptr_i[31:0];
      4'd3:    wdat = wi[0] ? arg_ptr_i[63:32]   : arg_ptr_i[31:0];
      4'd4:    wdat = wi[0] ? scratch_item_i     : scratch_lo_i;
      4'd5, 4'd6, 4'd7: wdat = q_r;
      4'd8:    wdat = wg_id_i[0 +: DW];
      4'd9:    wdat = wg_id_i[DW +: DW];
      4'd10:   wdat = wg_id_i[2*DW +: DW];
      4'd11:   wdat = wofs;
      4'd12:   wdat = info;
      default: wdat = '0;
    endcase
  end

  assign wr_en_o   = (st == S_RUN) && !need_div;
  assign wr_idx_o  = base_idx_i + off;
  assign wr_data_o = wdat;
  assign busy_o    = (st != S_IDLE);
  assign done_o    = done_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pend   <= '0;
      wi     <= '0;
      off    <= '0;
      have_q <= 1'b0;
      q_r    <= '0;
      rem    <= '0;
      quo    <= '0;
      dcnt   <= '0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          if (field_en_i == '0) begin
            done_r <= 1'b1;
          end else begin
            pend   <= field_en_i;
            wi     <= '0;
            off    <= '0;
            have_q <= 1'b0;
            st     <= S_RUN;
          end
        end
        S_RUN: if (need_div) begin
          rem  <= '0;
          quo  <= dvd;
          dcnt <= CNTW'(DW);
          st   <= S_DIV;
        end else begin
          off <= off + 1'b1;
          if (last_w) begin
            pend   <= pend_rest;
            wi     <= '0;
            have_q <= 1'b0;
            if (pend_rest == '0) begin
              st     <= S_IDLE;
              done_r <= 1'b1;
            end
          end else begin
            wi <= wi + 1'b1;
          end
        end
        S_DIV: begin
          rem  <= rem_n;
          quo  <= quo_n;
          dcnt <= dcnt - 1'b1;
          if (dcnt == CNTW'(1)) begin
            q_r    <= quo_n + DW'(rem_n != '0);
            have_q <= 1'b1;
            st     <= S_RUN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [5:0] wcnt;
  always_ff @(posedge clk) begin
    if (!rst_n || st == S_IDLE) wcnt <= '0;
    else if (wr_en_o)           wcnt <= wcnt + 1'b1;
  end

  // R1
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && $past(wr_en_o)) |-> (wr_idx_o == $past(wr_idx_o) + 1'b1));

  // R1
  slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (wcnt < MAXW));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  run_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));

  // R9
  empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && field_en_i == '0) |=> (done_o && !wr_en_o && !busy_o));

endmodule

// File: tb/wave_reg_init_bench.sv
module wave_reg_init_bench;
  localparam int CLK_P = 10;
  localparam int LIMIT = 150000;

  logic clk = 0, rst_n = 0, start = 0;
  logic [12:0] mask = '0;
  logic [7:0] base = '0;
  logic [127:0] desc = '0;
  logic [63:0] dptr = '0, qptr = '0, aptr = '0;
  logic [31:0] s_lo = '0, s_item = '0;
  logic [95:0] grid = {3{32'd1}}, wgs = {3{32'd1}}, wgid = '0;
  logic [31:0] wlin = '0, witems = 32'd1, wid = '0, wsize = 32'd1, wkb = '0;
  logic [5:0] app = '0;
  logic wr_en, busy, done;
  logic [7:0] wr_idx;
  logic [31:0] wr_data;

  wave_reg_init u_wave_reg_init (
    .clk(clk), .rst_n(rst_n), .start_i(start), .field_en_i(mask),
    .base_idx_i(base), .seg_desc_i(desc), .disp_ptr_i(dptr),
    .queue_ptr_i(qptr), .arg_ptr_i(aptr), .scratch_lo_i(s_lo),
    .scratch_item_i(s_item), .grid_size_i(grid), .wg_size_i(wgs),
    .wg_id_i(wgid), .wg_lin_i(wlin), .wg_items_i(witems),
    .wave_id_i(wid), .wave_size_i(wsize), .wave_kb_i(wkb),
    .append_i(app), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .wr_data_o(wr_data), .busy_o(busy), .done_o(done));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int ngot = 0, ndone = 0, nexp = 0;
  logic [7:0]  got_idx [0:63];
  logic [31:0] got_dat [0:63];
  logic [7:0]  exp_idx [0:31];
  logic [31:0] exp_dat [0:31];
  string       exp_tag [0:31];

  always @(negedge clk) begin
    if (wr_en && ngot < 64) begin
      got_idx[ngot] = wr_idx;
      got_dat[ngot] = wr_data;
      ngot++;
    end
    if (done) ndone++;
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT) begin
      fails++;
      $display("FAIL watchdog: actual cycles %0d expected below %0d", cyc, LIMIT);
      finish_run();
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ceil_div(logic [31:0] a, logic [31:0] b);
    logic [63:0] r;
    r = ({32'd0, a} + {32'd0, b} - 64'd1) / {32'd0, b};
    return r[31:0];
  endfunction

  task automatic push(logic [31:0] d, string tag);
    exp_idx[nexp] = base + 8'(nexp);
    exp_dat[nexp] = d;
    exp_tag[nexp] = tag;
    nexp++;
  endtask

  task automatic build_exp();
    logic [31:0] t, nw;
    nexp = 0;
    for (int f = 0; f < 13; f++) begin
      if (mask[f]) begin
        case (f)
          0: for (int w = 0; w < 4; w++) push(desc[w*32 +: 32], "R2");
          1: begin push(dptr[31:0], "R3"); push(dptr[63:32], "R3"); end
          2: begin push(qptr[31:0], "R3"); push(qptr[63:32], "R3"); end
          3: begin push(aptr[31:0], "R3"); push(aptr[63:32], "R3"); end
          4: begin push(s_lo, "R4"); push(s_item, "R4"); end
          5, 6, 7: push(ceil_div(grid[(f-5)*32 +: 32], wgs[(f-5)*32 +: 32]), "R5");
          8, 9, 10: push(wgid[(f-8)*32 +: 32], "R1");
          11: begin
            t = wlin * (witems >> 6) + wid;
            t = t * wkb;
            push(t << 10, "R6");
          end
          default: begin
            nw = ceil_div(witems, wsize);
            t = {(wid == 0), 19'd0, app, nw[5:0]};
            push(t, "R7");
          end
        endcase
      end
    end
  endtask

  task automatic rand_inputs();
    base = 8'($urandom_range(0, 229));
    desc = {$urandom, $urandom, $urandom, $urandom};
    dptr = {$urandom, $urandom};
    qptr = {$urandom, $urandom};
    aptr = {$urandom, $urandom};
    s_lo = $urandom; s_item = $urandom & 32'hFFFF_FFFC;
    for (int d = 0; d < 3; d++) begin
      grid[d*32 +: 32] = $urandom_range(1, 100000);
      wgs[d*32 +: 32]  = $urandom_range(1, 1024);
      wgid[d*32 +: 32] = $urandom_range(0, 5000);
    end
    wlin = $urandom_range(0, 20000); witems = $urandom_range(1, 1024);
    wid = $urandom_range(0, 15); wsize = $urandom_range(1, 64);
    wkb = $urandom_range(0, 64); app = 6'($urandom);
  endtask

  task automatic launch(string tag, int mid_start);
    build_exp();
    ngot = 0; ndone = 0;
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    if (mid_start > 0) begin
      repeat (mid_start) @(negedge clk);
      mask = 13'h1FFF ^ mask;
      start = 1;
      @(negedge clk);
      start = 0;
    end
    for (int k = 0; k < 2000 && ndone == 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(ndone == 1, {"R8 done count ", tag}, ndone, 1);
    chk(ngot == nexp, {"R1 write count ", tag}, ngot, nexp);
    for (int i = 0; i < nexp && i < ngot; i++) begin
      chk(got_idx[i] == exp_idx[i], {"R1 slot ", tag}, 32'(got_idx[i]), 32'(exp_idx[i]));
      chk(got_dat[i] == exp_dat[i], {exp_tag[i], " data ", tag}, got_dat[i], exp_dat[i]);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 reset state
    chk(!wr_en && !busy && !done, "R8 reset outputs", {29'd0, wr_en, busy, done}, 0);

    // R9 empty mask: done the cycle after start, no writes
    rand_inputs(); mask = '0; ngot = 0; ndone = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(done == 1'b1, "R9 done next cycle", 32'(done), 1);
    chk(!busy, "R9 not busy", 32'(busy), 0);
    repeat (3) @(negedge clk);
    chk(ngot == 0, "R9 no writes", ngot, 0);

    // directed R5: exact and inexact division
    rand_inputs(); mask = 13'h00E0;
    grid = {32'd1, 32'd257, 32'd256}; wgs = {32'd1, 32'd64, 32'd64};
    launch("grid exact/inexact", 0);

    // directed R7: wave 0, item count just above one wave
    rand_inputs(); mask = 13'h1000; wid = 0; witems = 65; wsize = 64; app = 6'h2A;
    launch("info wave0", 0);
    rand_inputs(); mask = 13'h1000; wid = 3; witems = 64; wsize = 64;
    launch("info wave3", 0);

    // directed R6 and all fields
    rand_inputs(); mask = 13'h0800; wlin = 7; witems = 256; wid = 2; wkb = 4;
    launch("wave offset", 0);
    rand_inputs(); mask = 13'h1FFF;
    launch("all fields", 0);

    // R8: start while busy is ignored
    rand_inputs(); mask = 13'h1FFF;
    launch("mid start", 5);

    for (int n = 0; n < 40; n++) begin
      rand_inputs();
      mask = 13'($urandom);
      launch("random", 0);
    end
    finish_run();
  end
endmodule